// File: doc/BRIEF.md
# Keyed Flash Command Controller

This block is the register front end that turns software writes into program and erase operations on an on-chip flash macro. Software first takes an ownership lock and loads a target address and eight 32-bit data words. It then writes a magic unlock value into a key register and, straight after that, writes the command into the control register. An accepted command is handed to the flash macro as a single-cycle start pulse. A busy status stays up until the macro acknowledges. On completion a done flag is raised. A rejected command sets an error flag and never reaches the macro.

The key is single-use: the next write to either the control register or the bank-swap register consumes it. A second key value, distinct from the program key, protects a bank-swap bit that selects which flash bank is mapped as active. Program operations cover one 32-byte line and must be line-aligned. Erase operations act on the sector that contains the address. The flash macro is a model outside this block. It stores the AND of the old and the new data on a program, and fills a sector with ones on an erase.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, status, flags, the lock register and the swap register all read 0, `bank_swap` is 0, and no start pulse is issued.
- R2: With the program key 0x91C32C01 loaded, writing the control register (offset 0x00) with bit 7 set and bits [3:0] = 0x2 starts a 32-byte program at the address register (offset 0x20). Data register k (offset 0x28+4k, k = 0..7) supplies bytes 4k..4k+3 of the line, least significant byte first.
- R3: With the same key, an erase command (op bits 0x4, bit 7 set) starts an erase at the address with its low log2(sector size) bits cleared. The default sector size is 256 bytes.
- R4: Status bit 0 (offset 0x18) reads 1 from the cycle after a command is accepted until the macro acknowledges. Address and data register writes made while busy are ignored.
- R5: Flag bit 0 (offset 0x14) is set when the macro acknowledges. Writing the flag register clears every bit written as 1, so all ones clears every flag.
- R6: The key (offset 0x1C) is consumed by the next control or swap write. A program or erase command without the program key runs no operation and sets flag bit 1. The value 0x91C32C04 unlocks nothing.
- R7: A program command whose address has any of bits [4:0] set runs no operation and sets flag bit 2.
- R8: The lock register (offset 0x08) holds the lock in bit 0 and the owner in bits [2:1], where owner 01 is the CPU. Writing 0x3 while unlocked makes it read 0x3. Writing 0x2 releases it, and it then reads 0x2.
- R9: A keyed program or erase command issued while the lock register does not read 0x3 runs no operation and sets flag bit 3.
- R10: Bit 8 of the swap register (offset 0x48) drives `bank_swap`. It takes the written value only when the swap key 0x91C32C02 was loaded. Otherwise it keeps its value and flag bit 1 is set.
- R11: A control write with op 0x0, or with bit 7 clear, starts no operation and sets no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| fl_start | output | 1 | One-cycle operation start to the flash macro |
| fl_erase | output | 1 | 1 = erase, 0 = program; held while busy |
| fl_addr | output | ADDR_W | Operation byte address (sector base for erase) |
| fl_data | output | 32*WORDS | Program line, word k at bits [32k+31:32k] |
| fl_ack | input | 1 | Macro completion pulse |
| bank_swap | output | 1 | Active-bank selection |

## Verification
A wrong key or lock state shows up in the flag register in the cycle after the command write. A wrongly rejected or wrongly accepted command shows up a few cycles later as a missing or an extra change in the flash contents. A busy bit stuck high shows up as a status poll that never ends, and a busy bit stuck low shows up as address writes that leak into the operation in flight. A swap bit that changes without its key is visible on `bank_swap` on the next cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [31:0] KEY_PROG = 32'h91C32C01;
  localparam logic [31:0] KEY_SWAP = 32'h91C32C02;

  localparam logic [3:0] OP_PROG  = 4'h2;
  localparam logic [3:0] OP_ERASE = 4'h4;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_LOCK   = 8'h08;
  localparam logic [7:0] OFS_FLAGS  = 8'h14;
  localparam logic [7:0] OFS_STATUS = 8'h18;
  localparam logic [7:0] OFS_KEY    = 8'h1C;
  localparam logic [7:0] OFS_ADDR   = 8'h20;
  localparam logic [7:0] OFS_DATA0  = 8'h28;
  localparam logic [7:0] OFS_SWAP   = 8'h48;

  localparam int FLG_DONE  = 0;
  localparam int FLG_KEY   = 1;
  localparam int FLG_ALIGN = 2;
  localparam int FLG_OWNER = 3;
  localparam int NFLAGS    = 4;

  localparam int SWAP_BIT = 8;

  function automatic logic [31:0] sector_base(input logic [31:0] a, input int unsigned lg);
    return a & ~((32'd1 << lg) - 32'd1);
  endfunction

  function automatic logic line_aligned(input logic [31:0] a, input int unsigned lg);
    return (a & ((32'd1 << lg) - 32'd1)) == 32'd0;
  endfunction
endpackage

// File: rtl/flash_key_gate.sv
module flash_key_gate
  import flash_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [31:0] key_val,
  input  logic        consume,
  output logic        prog_ok,
  output logic        swap_ok
);
  logic [31:0] key_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       key_q <= '0;
    else if (consume) key_q <= '0;
    else if (key_wr)  key_q <= key_val;
  end

  assign prog_ok = (key_q == KEY_PROG);
  assign swap_ok = (key_q == KEY_SWAP);
endmodule

// File: rtl/flash_lock.sv
module flash_lock (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [2:0] wval,
  output logic [2:0] value,
  output logic       held
);
  always_ff @(posedge clk) begin
    if (!rst_n) value <= 3'b000;
    else if (wr) begin
      if (wval == 3'b011 && !value[0]) value <= 3'b011;
      else if (wval == 3'b010)         value <= 3'b010;
    end
  end

  assign held = (value == 3'b011);
endmodule

// File: rtl/flash_flags.sv
module flash_flags #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_vec,
  input  logic          clr_wr,
  input  logic [NF-1:0] clr_vec,
  output logic [NF-1:0] flags
);
  logic [NF-1:0] clr_mask;
  assign clr_mask = clr_wr ? clr_vec : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_mask) | set_vec;
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int WORDS       = 8,
  parameter int SECTOR_LOG2 = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [7:0]            bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  fl_start,
  output logic                  fl_erase,
  output logic [ADDR_W-1:0]     fl_addr,
  output logic [32*WORDS-1:0]   fl_data,
  input  logic                  fl_ack,
  output logic                  bank_swap
);
  localparam int LINE_LOG2 = $clog2(WORDS * 4);

  logic wr_ctrl, wr_swap, wr_key, wr_lock, wr_flags, wr_addr;
  logic prog_ok, swap_ok, lock_held;
  logic [2:0] lock_val;
  logic [NFLAGS-1:0] flags, set_vec;
  logic busy_q, start_q, erase_q, swap_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0] data_q [WORDS];

  // decoded events, kept as named wires for the checker
  logic [3:0] op;
  logic cmd_real, is_prog, misaligned;
  logic key_rej, own_rej, align_rej, cmd_fire, swap_rej, swap_take, ack_seen;

  assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_swap  = bus_wr && (bus_addr == OFS_SWAP);
  assign wr_key   = bus_wr && (bus_addr == OFS_KEY);
  assign wr_lock  = bus_wr && (bus_addr == OFS_LOCK);
  assign wr_flags = bus_wr && (bus_addr == OFS_FLAGS);
  assign wr_addr  = bus_wr && (bus_addr == OFS_ADDR) && !busy_q;

  assign op         = bus_wdata[3:0];
  assign is_prog    = (op == OP_PROG);
  assign cmd_real   = wr_ctrl && bus_wdata[7] && (is_prog || op == OP_ERASE) && !busy_q;
  assign misaligned = is_prog && !line_aligned(32'(addr_q), LINE_LOG2);

  assign key_rej   = cmd_real && !prog_ok;
  assign own_rej   = cmd_real && prog_ok && !lock_held;
  assign align_rej = cmd_real && prog_ok && lock_held && misaligned;
  assign cmd_fire  = cmd_real && prog_ok && lock_held && !misaligned;
  assign swap_rej  = wr_swap && !swap_ok;
  assign swap_take = wr_swap && swap_ok;
  assign ack_seen  = fl_ack && busy_q;

  flash_key_gate u_key (
    .clk(clk), .rst_n(rst_n), .key_wr(wr_key), .key_val(bus_wdata),
    .consume(wr_ctrl || wr_swap), .prog_ok(prog_ok), .swap_ok(swap_ok)
  );

  flash_lock u_lock (
    .clk(clk), .rst_n(rst_n), .wr(wr_lock), .wval(bus_wdata[2:0]),
    .value(lock_val), .held(lock_held)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[FLG_DONE]  = ack_seen;
    set_vec[FLG_KEY]   = key_rej || swap_rej;
    set_vec[FLG_ALIGN] = align_rej;
    set_vec[FLG_OWNER] = own_rej;
  end

  flash_flags #(.NF(NFLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_wr(wr_flags),
    .clr_vec(bus_wdata[NFLAGS-1:0]), .flags(flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      erase_q <= 1'b0;
      swap_q  <= 1'b0;
      addr_q  <= '0;
    end else begin
      start_q <= cmd_fire;
      if (cmd_fire) begin
        busy_q  <= 1'b1;
        erase_q <= !is_prog;
      end else if (fl_ack) begin
        busy_q <= 1'b0;
      end
      if (wr_addr)   addr_q <= bus_wdata[ADDR_W-1:0];
      if (swap_take) swap_q <= bus_wdata[SWAP_BIT];
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_data
    logic wr_word;
    assign wr_word = bus_wr && !busy_q && (bus_addr == OFS_DATA0 + 8'(4 * w));
    always_ff @(posedge clk) begin
      if (!rst_n)       data_q[w] <= '0;
      else if (wr_word) data_q[w] <= bus_wdata;
    end
    assign fl_data[32*w +: 32] = data_q[w];
  end

  assign fl_start  = start_q;
  assign fl_erase  = erase_q;
  assign fl_addr   = erase_q ? ADDR_W'(sector_base(32'(addr_q), SECTOR_LOG2)) : addr_q;
  assign bank_swap = swap_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_LOCK:   bus_rdata = {29'd0, lock_val};
      OFS_FLAGS:  bus_rdata = {{(32-NFLAGS){1'b0}}, flags};
      OFS_STATUS: bus_rdata = {31'd0, busy_q};
      OFS_ADDR:   bus_rdata = 32'(addr_q);
      OFS_SWAP:   bus_rdata = 32'(swap_q) << SWAP_BIT;
      default:    bus_rdata = '0;
    endcase
    for (int w = 0; w < WORDS; w++)
      if (bus_addr == OFS_DATA0 + 8'(4 * w)) bus_rdata = data_q[w];
  end
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
  parameter int ADDR_W      = 16,
  parameter int LINE_LOG2   = 5,
  parameter int SECTOR_LOG2 = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fl_start,
  input logic              fl_erase,
  input logic [ADDR_W-1:0] fl_addr,
  input logic              fl_ack,
  input logic              bank_swap,
  input logic              busy_q,
  input logic              cmd_fire,
  input logic              prog_ok,
  input logic              swap_ok,
  input logic              lock_held,
  input logic [3:0]        flags
);
  localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'((1 << LINE_LOG2) - 1);
  localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'((1 << SECTOR_LOG2) - 1);

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |=> !fl_start);
  assert_busy_after_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> busy_q);
  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(fl_addr));
  assert_done_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_ack && busy_q) |=> flags[0]);
  assert_fire_keyed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |-> prog_ok);
  assert_prog_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_start && !fl_erase) |-> ((fl_addr & LINE_MASK) == '0));
  assert_erase_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_start && fl_erase) |-> ((fl_addr & SECT_MASK) == '0));
  assert_fire_owned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |-> lock_held);
  assert_swap_keyed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_swap != $past(bank_swap)) |-> $past(swap_ok));
endmodule

bind flash_cmd_ctrl flash_cmd_checker #(
  .ADDR_W(ADDR_W), .LINE_LOG2(LINE_LOG2), .SECTOR_LOG2(SECTOR_LOG2)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fl_start(fl_start), .fl_erase(fl_erase),
  .fl_addr(fl_addr), .fl_ack(fl_ack), .bank_swap(bank_swap), .busy_q(busy_q),
  .cmd_fire(cmd_fire), .prog_ok(prog_ok), .swap_ok(swap_ok),
  .lock_held(lock_held), .flags(flags)
);

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
  localparam int MEMB = 1024;
  localparam logic [31:0] KP = 32'h91C32C01, KS = 32'h91C32C02, KC = 32'h91C32C04;

  logic clk = 0, rst_n = 0, bus_wr = 0, fl_ack = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic fl_start, fl_erase, bank_swap;
  logic [15:0] fl_addr;
  logic [255:0] fl_data;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  flash_cmd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fl_start(fl_start),
    .fl_erase(fl_erase), .fl_addr(fl_addr), .fl_data(fl_data),
    .fl_ack(fl_ack), .bank_swap(bank_swap)
  );

  // behavioural flash macro: AND on program, ones on erase, ack 4 cycles on
  logic [7:0] mem [MEMB];
  logic [7:0] exp_mem [MEMB];
  int cnt = 0;
  int starts = 0;
  always @(posedge clk) begin
    fl_ack <= 1'b0;
    if (!rst_n) begin
      for (int i = 0; i < MEMB; i++) mem[i] <= 8'hFF;
      cnt <= 0;
    end else if (fl_start) begin
      cnt <= 4;
      starts <= starts + 1;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        fl_ack <= 1'b1;
        if (fl_erase)
          for (int b = 0; b < 256; b++) mem[(int'(fl_addr) + b) % MEMB] <= 8'hFF;
        else
          for (int b = 0; b < 32; b++)
            mem[(int'(fl_addr) + b) % MEMB] <= mem[(int'(fl_addr) + b) % MEMB] & fl_data[8*b +: 8];
      end
    end
  end

  // key[55:24] op[23:20] addr[19:4] expected flags[3:0]
  localparam logic [55:0] VEC [8] = '{
    {KP, 4'h2, 16'h0040, 4'h1},
    {KP, 4'h2, 16'h0040, 4'h1},
    {KP, 4'h4, 16'h007F, 4'h1},
    {KC, 4'h2, 16'h0100, 4'h2},
    {KP, 4'h2, 16'h0104, 4'h4},
    {KS, 4'h4, 16'h0100, 4'h2},
    {KP, 4'h0, 16'h0000, 4'h0},
    {KP, 4'h2, 16'h03E0, 4'h1}
  };

  function automatic logic [31:0] pat(int v, int w);
    return 32'hC3A50F69 ^ (32'(v) * 32'h01030507) ^ (32'(w) * 32'h11111111);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bw(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic br(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 100; i++) begin
      br(8'h18, s);
      if (s[0] == 1'b0) return;
      @(negedge clk);
    end
  endtask

  task automatic load_line(int v, logic [15:0] a);
    bw(8'h20, 32'(a));
    for (int w = 0; w < 8; w++) bw(8'h28 + 8'(4 * w), pat(v, w));
  endtask

  task automatic exp_prog(int v, logic [15:0] a);
    for (int b = 0; b < 32; b++) begin
      logic [31:0] wd;
      wd = pat(v, b / 4);
      exp_mem[(int'(a) + b) % MEMB] &= wd[8*(b%4) +: 8];
    end
  endtask

  task automatic exp_erase(logic [15:0] a);
    int base;
    base = int'(a) - (int'(a) % 256);
    for (int b = 0; b < 256; b++) exp_mem[(base + b) % MEMB] = 8'hFF;
  endtask

  task automatic check_mem(string req);
    int diffs;
    int first;
    diffs = 0;
    first = 0;
    for (int i = 0; i < MEMB; i++)
      if (mem[i] !== exp_mem[i]) begin
        if (diffs == 0) first = i;
        diffs++;
      end
    check({req, " flash contents (first differing byte index as actual)"},
          diffs == 0 ? 32'd0 : 32'(first) | 32'h8000_0000, 32'd0);
  endtask

  logic [31:0] r;

  initial begin
    for (int i = 0; i < MEMB; i++) exp_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    br(8'h18, r); check("R1 status", r, 0);
    br(8'h14, r); check("R1 flags", r, 0);
    br(8'h08, r); check("R1 lock", r, 0);
    br(8'h48, r); check("R1 swap", r, 0);
    check("R1 bank_swap", 32'(bank_swap), 0);
    check("R1 no start", 32'(starts), 0);

    // R9 command without holding the lock
    load_line(99, 16'h0000);
    bw(8'h1C, KP); bw(8'h00, 32'h84);
    repeat (6) @(negedge clk);
    br(8'h14, r); check("R9 unowned erase flag bit3", r, 32'h8);
    check_mem("R9");
    bw(8'h14, 32'hFFFF_FFFF);

    // R8 take the lock
    bw(8'h08, 32'h3); br(8'h08, r); check("R8 take lock", r, 32'h3);
    bw(8'h08, 32'h3); br(8'h08, r); check("R8 retake keeps", r, 32'h3);

    // vector table: R2 R3 R5 R6 R7 R11
    for (int v = 0; v < 8; v++) begin
      logic [31:0] k;
      logic [3:0] o, ef;
      logic [15:0] a;
      k = VEC[v][55:24]; o = VEC[v][23:20]; a = VEC[v][19:4]; ef = VEC[v][3:0];
      load_line(v, a);
      bw(8'h1C, k);
      bw(8'h00, 32'h80 | 32'(o));
      repeat (2) @(negedge clk);
      wait_idle();
      if (ef == 4'h1 && o == 4'h2) exp_prog(v, a);
      if (ef == 4'h1 && o == 4'h4) exp_erase(a);
      br(8'h14, r);
      check($sformatf("R2/R3/R6/R7/R11 vector %0d flags", v), r, 32'(ef));
      check_mem($sformatf("R2/R3/R6/R7/R11 vector %0d", v));
      bw(8'h14, 32'hFFFF_FFFF);
    end

    // R4 busy and ignored writes while busy
    load_line(20, 16'h0200);
    bw(8'h1C, KP); bw(8'h00, 32'h82);
    br(8'h18, r); check("R4 busy after accept", r, 1);
    bw(8'h20, 32'h0300);
    bw(8'h28, 32'h0);
    wait_idle();
    br(8'h20, r); check("R4 addr write while busy ignored", r, 32'h0200);
    br(8'h28, r); check("R4 data write while busy ignored", r, pat(20, 0));
    exp_prog(20, 16'h0200);
    check_mem("R4");
    br(8'h14, r); check("R5 done flag", r, 32'h1);

    // R5 write-1-to-clear
    bw(8'h00, 32'h82);
    br(8'h14, r); check("R6 unkeyed cmd flag", r, 32'h3);
    bw(8'h14, 32'h2);
    br(8'h14, r); check("R5 partial clear", r, 32'h1);
    bw(8'h14, 32'hFFFF_FFFF);
    br(8'h14, r); check("R5 all-ones clear", r, 32'h0);

    // R6 key consumed by a control write without go
    bw(8'h1C, KP); bw(8'h00, 32'h02); bw(8'h00, 32'h82);
    repeat (6) @(negedge clk);
    br(8'h14, r); check("R6 consumed key rejects", r, 32'h2);
    check_mem("R6 consumed key");
    bw(8'h14, 32'hFFFF_FFFF);

    // R10 bank swap
    bw(8'h48, 32'h100);
    br(8'h48, r); check("R10 unkeyed swap ignored", r, 0);
    br(8'h14, r); check("R10 unkeyed swap flag", r, 32'h2);
    bw(8'h14, 32'hFFFF_FFFF);
    bw(8'h1C, KS); bw(8'h48, 32'h100);
    br(8'h48, r); check("R10 keyed swap", r, 32'h100);
    check("R10 bank_swap pin", 32'(bank_swap), 1);
    bw(8'h1C, KP); bw(8'h48, 32'h0);
    br(8'h48, r); check("R10 program key does not swap", r, 32'h100);
    bw(8'h14, 32'hFFFF_FFFF);

    // R8 release, then R9 rejection
    bw(8'h08, 32'h2); br(8'h08, r); check("R8 release", r, 32'h2);
    load_line(30, 16'h0020);
    bw(8'h1C, KP); bw(8'h00, 32'h82);
    repeat (6) @(negedge clk);
    br(8'h14, r); check("R9 released lock rejects", r, 32'h8);
    check_mem("R9 released");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule